// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches the traffic of a 32-bit core: the address of every instruction fetch, and the effective address and data of every load or store. Eight comparators each hold a reference value and a 2-bit condition. Four of them look at the fetch address. Two look at the load/store address, and two look at the load/store data. Their results form six watchpoint events. Four of the events are instruction events and two are load/store events. The events appear on a six-bit output one cycle after the access that caused them.

Each event can also be routed to its own 16-bit countdown. The countdown requests a breakpoint after a programmed number of qualifying events. This lets a debugger stop on, for example, the fifth time a loop passes an address. Software sets everything through a simple write-only register port. Halting the core and the debug serial link are handled outside this block.

Top module: `wpt_unit`

## Requirements
- R1: After reset, `wp_out` and `brk_req` are 0. All reference values, conditions, enables and counters are 0.
- R2: Configuration write map, selected by `cfg_addr` on a cycle with `cfg_we`:
  - 0 to 7 hold the comparator reference values. 0 to 3 are fetch address, 4 and 5 are load/store address, 6 and 7 are load/store data.
  - 8 holds the conditions, with comparator k in bits [2k+1:2k].
  - 9 holds the enables: bits [5:0] enable the watchpoints, and bits [7:6] enable data matching for load/store watchpoints 0 and 1.
  - 10 bits [5:0] enable the breakpoint countdown of each watchpoint.
  - 16 to 21 reload the countdowns of watchpoints 0 to 5 from bits [15:0].
  - A write takes effect from the next cycle.
- R3: The condition codes compare the observed value v against the reference r, unsigned: 00 tests v == r, 01 tests v != r, 10 tests v < r, and 11 tests v > r.
- R4: `wp_out[i]` (i = 0..3) is 1 in the cycle after a cycle in which `if_valid`, the enable of watchpoint i and comparator i on `if_addr` are all true. Otherwise it is 0.
- R5: `wp_out[4+j]` (j = 0,1) is 1 in the cycle after a cycle in which all of the following hold:
  - `ls_valid` is high,
  - watchpoint 4+j is enabled,
  - comparator 4+j matches `ls_addr`,
  - and, when the data-match enable j is set, comparator 6+j matches `ls_data`.
- R6: Without a valid fetch or load/store strobe, and for a disabled watchpoint, the corresponding `wp_out` bits stay 0 whatever the addresses and data are.
- R7: An event of a watchpoint whose countdown is enabled decrements its counter, which stops at 0. The event raises `brk_req` for one cycle, aligned with `wp_out`, when the count before the event is 1 or 0. Counting down from a reload of N therefore breaks on the N-th event, and on every later event until the next reload.
- R8: A countdown reload in the same cycle as an event of that watchpoint wins: the counter takes the written value, and that event neither counts nor raises `brk_req`.
- R9: Events of a watchpoint whose countdown is disabled leave its counter unchanged and never raise `brk_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| if_valid | input | 1 | Fetch address valid |
| if_addr | input | 32 | Instruction fetch address |
| ls_valid | input | 1 | Load/store access valid |
| ls_addr | input | 32 | Load/store effective address |
| ls_data | input | 32 | Load/store data |
| wp_out | output | 6 | Watchpoint events: [3:0] instruction, [5:4] load/store |
| brk_req | output | 1 | One-cycle breakpoint request |

## Verification
The hardest situation to reach is a countdown reload that lands in the very cycle an event of the same watchpoint occurs. Close to it is a countdown that has already expired and keeps firing on each later event. The directed part of the stimulus places the reload write and a matching fetch on the same clock edge. It then drives repeated hits past expiry. A long random phase follows. It mixes configuration writes with fetches and loads/stores drawn from a small pool of addresses, so matches, magnitude conditions and collisions keep recurring. A cycle-by-cycle reference model checks every cycle of this phase.

// File: rtl/wpt_unit.sv
module wpt_unit #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CNTW = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [4:0]                       cfg_addr,
  input  logic [((AW > DW) ? AW : DW)-1:0] cfg_wdata,
  input  logic                             if_valid,
  input  logic [AW-1:0]                    if_addr,
  input  logic                             ls_valid,
  input  logic [AW-1:0]                    ls_addr,
  input  logic [DW-1:0]                    ls_data,
  output logic [5:0]                       wp_out,
  output logic                             brk_req
);
  localparam int RW = (AW > DW) ? AW : DW;
  localparam int NC = 8;
  localparam int NW = 6;

  logic [RW-1:0]   refv [NC];
  logic [2*NC-1:0] cond;
  logic [7:0]      wpen;
  logic [NW-1:0]   brken;
  logic [CNTW-1:0] cnt  [NW];
  logic [RW-1:0]   opnd [NC];
  logic [NC-1:0]   hit;
  logic [NW-1:0]   wp_now;
  logic [NW-1:0]   fire;

  function automatic logic cmp(input logic [RW-1:0] v, input logic [RW-1:0] r,
                               input logic [1:0] c);
    case (c)
      2'b00:   return v == r;
      2'b01:   return v != r;
      2'b10:   return v < r;
      default: return v > r;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) refv[k] <= '0;
      cond  <= '0;
      wpen  <= '0;
      brken <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < 5'(NC)) refv[cfg_addr[2:0]] <= cfg_wdata;
      else if (cfg_addr == 5'd8)  cond  <= cfg_wdata[2*NC-1:0];
      else if (cfg_addr == 5'd9)  wpen  <= cfg_wdata[7:0];
      else if (cfg_addr == 5'd10) brken <= cfg_wdata[NW-1:0];
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_cmp
    if (k < 4) begin : g_if
      assign opnd[k] = RW'(if_addr);
    end else if (k < 6) begin : g_la
      assign opnd[k] = RW'(ls_addr);
    end else begin : g_ld
      assign opnd[k] = RW'(ls_data);
    end
    assign hit[k] = cmp(opnd[k], refv[k], cond[2*k +: 2]);
  end

  for (genvar i = 0; i < 4; i++) begin : g_iwp
    assign wp_now[i] = if_valid & wpen[i] & hit[i];
  end
  for (genvar j = 0; j < 2; j++) begin : g_lwp
    assign wp_now[4+j] = ls_valid & wpen[4+j] & hit[4+j] & (~wpen[6+j] | hit[6+j]);
  end

  for (genvar i = 0; i < NW; i++) begin : g_cnt
    logic reload;
    logic count;
    assign reload  = cfg_we && (cfg_addr == 5'(16 + i));
    assign count   = wp_now[i] & brken[i] & ~reload;
    assign fire[i] = count & (cnt[i] <= CNTW'(1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt[i] <= '0;
      else if (reload)                  cnt[i] <= cfg_wdata[CNTW-1:0];
      else if (count && cnt[i] != '0)   cnt[i] <= cnt[i] - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_out  <= '0;
      brk_req <= 1'b0;
    end else begin
      wp_out  <= wp_now;
      brk_req <= |fire;
    end
  end
endmodule

module wpt_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        if_valid,
  input logic [31:0] if_addr,
  input logic        ls_valid,
  input logic [5:0]  wp_out,
  input logic        brk_req,
  input logic [7:0]  wpen,
  input logic [5:0]  brken,
  input logic [15:0] cond,
  input logic [31:0] ref0
);
  AST_IF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !if_valid |=> wp_out[3:0] == 4'b0); // R6
  AST_LS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_valid |=> wp_out[5:4] == 2'b0); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wpen[5:0] == 6'b0 |=> wp_out == 6'b0); // R6
  AST_EQ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && wpen[0] && cond[1:0] == 2'b00 && if_addr == ref0) |=> wp_out[0]); // R4
  AST_BRK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (wp_out & $past(brken)) != 6'b0); // R7
endmodule

bind wpt_unit wpt_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_addr(if_addr),
  .ls_valid(ls_valid), .wp_out(wp_out), .brk_req(brk_req),
  .wpen(wpen), .brken(brken), .cond(cond), .ref0(refv[0])
);

// File: tb/test_wpt_unit.sv
`timescale 1ns/1ps
module test_wpt_unit;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [4:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic if_valid = 0; logic [31:0] if_addr = 0;
  logic ls_valid = 0; logic [31:0] ls_addr = 0, ls_data = 0;
  logic [5:0] wp_out; logic brk_req;

  wpt_unit i_wpt_unit (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] m_ref [8];
  logic [1:0]  m_cnd [8];
  logic [7:0]  m_en;
  logic [5:0]  m_ben;
  int          m_cnt [6];
  logic [5:0]  exp_wp;
  logic        exp_brk;

  function automatic bit mhit(logic [31:0] v, logic [31:0] r, logic [1:0] c);
    if (c == 0) return v == r;
    if (c == 1) return v != r;
    if (c == 2) return v < r;
    return v > r;
  endfunction

  task automatic model();
    bit h [8]; logic [5:0] w; bit f = 0;
    for (int i = 0; i < 8; i++)
      h[i] = mhit(i < 4 ? if_addr : (i < 6 ? ls_addr : ls_data), m_ref[i], m_cnd[i]);
    for (int i = 0; i < 4; i++) w[i] = if_valid && m_en[i] && h[i];
    for (int j = 0; j < 2; j++)
      w[4+j] = ls_valid && m_en[4+j] && h[4+j] && (!m_en[6+j] || h[6+j]);
    for (int i = 0; i < 6; i++) begin
      bit wr = cfg_we && (cfg_addr == 5'(16 + i));
      if (w[i] && m_ben[i] && !wr) begin
        if (m_cnt[i] <= 1) f = 1;
        if (m_cnt[i] > 0) m_cnt[i]--;
      end
    end
    if (cfg_we) begin
      if (cfg_addr < 8) m_ref[cfg_addr] = cfg_wdata;
      else if (cfg_addr == 8) for (int k = 0; k < 8; k++) m_cnd[k] = cfg_wdata[2*k +: 2];
      else if (cfg_addr == 9) m_en = cfg_wdata[7:0];
      else if (cfg_addr == 10) m_ben = cfg_wdata[5:0];
      else if (cfg_addr >= 16 && cfg_addr <= 21) m_cnt[cfg_addr-16] = int'(cfg_wdata[15:0]);
    end
    exp_wp = w; exp_brk = f;
  endtask

  task automatic compare();
    checks++;
    if (wp_out !== exp_wp || brk_req !== exp_brk) begin
      fails++;
      $display("FAIL %s: wp_out=%b brk_req=%b expected wp_out=%b brk_req=%b",
               cur_req, wp_out, brk_req, exp_wp, exp_brk);
    end
  endtask

  task automatic cyc();
    @(posedge clk); model();
    @(negedge clk); compare();
    cfg_we = 0; if_valid = 0; ls_valid = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d; cyc();
  endtask
  task automatic fetch(input logic [31:0] a);
    if_valid = 1; if_addr = a; cyc();
  endtask
  task automatic lsa(input logic [31:0] a, input logic [31:0] d);
    ls_valid = 1; ls_addr = a; ls_data = d; cyc();
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin m_ref[k] = 0; m_cnd[k] = 0; end
    for (int k = 0; k < 6; k++) m_cnt[k] = 0;
    m_en = 0; m_ben = 0; exp_wp = 0; exp_brk = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare();
    rst_n = 1;
    cyc();

    cur_req = "R2";
    wr(0, 32'h100); wr(1, 32'h100); wr(2, 32'h100); wr(3, 32'h100);
    wr(4, 32'h2000); wr(5, 32'h3000); wr(6, 32'hAB); wr(7, 32'h10);
    wr(8, 32'h0000C0E4); wr(9, 32'h7F);

    cur_req = "R3";
    fetch(32'hFF); fetch(32'h100); fetch(32'h101); fetch(32'hFFFFFFFF); fetch(32'h0);
    cur_req = "R4";
    fetch(32'h100); cyc();

    cur_req = "R5";
    lsa(32'h2000, 32'hAB); lsa(32'h2000, 32'hAC); lsa(32'h3000, 32'h5);
    wr(9, 32'hFF);
    lsa(32'h3000, 32'h5); lsa(32'h3000, 32'h11);

    cur_req = "R6";
    if_addr = 32'h100; ls_addr = 32'h2000; ls_data = 32'hAB; cyc();
    wr(9, 32'h0); fetch(32'h100); lsa(32'h2000, 32'hAB);
    wr(9, 32'h3F);

    cur_req = "R7";
    wr(10, 32'h01); wr(16, 3);
    fetch(32'h100); cyc(); fetch(32'h100); fetch(32'hFF); fetch(32'h100);
    fetch(32'h100); fetch(32'h100);

    cur_req = "R8";
    wr(16, 2);
    cfg_we = 1; cfg_addr = 16; cfg_wdata = 2; if_valid = 1; if_addr = 32'h100; cyc();
    fetch(32'h100); fetch(32'h100);

    cur_req = "R9";
    wr(17, 1); fetch(32'h101); fetch(32'h101);
    wr(10, 32'h03); fetch(32'h101);

    cur_req = "R3";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] pool [6] = '{32'hFF, 32'h100, 32'h101, 32'h2000, 32'h3000, 32'hAB};
      if_valid = r[0]; if_addr = pool[r[3:1] % 6];
      ls_valid = r[4]; ls_addr = pool[r[7:5] % 6]; ls_data = pool[r[10:8] % 6];
      if (r[13:11] == 0) begin
        int a = int'(r[18:14]) % 22;
        cfg_we = 1; cfg_addr = 5'(a);
        cfg_wdata = (a < 8) ? pool[r[21:19] % 6] : (a >= 16 ? 32'(r[23:21] % 5) : $urandom);
      end
      cyc();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule